// File: doc/BRIEF.md
# Block Cipher Feedback Mode Unit

This unit sits around a 64-bit block cipher core that by itself only maps one block to another (electronic codebook behaviour). It adds the chaining needed for cipher block chaining (CBC) and 64-bit cipher feedback (CFB), in both the encrypt and the decrypt direction. It also passes blocks straight through for codebook (ECB) use. It keeps a copy of the incoming block, a result register for the outgoing block and a 64-bit chaining register. The chaining register is loaded from an initialization vector (IV).

The core is a black box reached through a start/done handshake. The unit works the same whether one pass of the core is a single DES or a full triple-DES run, because it only waits for `core_done`. A block is taken with a valid/ready handshake. The mode and direction are captured at that moment. The result is held until the consumer takes it, and only then is a new block accepted.

Top module: `cipher_mode_unit`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `core_start` is 0, and the chaining register is zero until the first IV write.
- R2: A block is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `core_start` is then 1 for exactly the next cycle, and `in_ready` stays 0 until the result is taken.
- R3: With `in_mode` = 2'b00 (ECB), the core gets the input block unchanged. `core_encrypt` = !`in_decrypt`, the output is the core result, and the chaining register is untouched.
- R4: With `in_mode` = 2'b01 (CBC) and `in_decrypt` = 0, the core gets input XOR chain with `core_encrypt` = 1. The output is the core result, which also becomes the new chain.
- R5: With `in_mode` = 2'b01 and `in_decrypt` = 1, the core gets the input with `core_encrypt` = 0. The output is core result XOR chain, and the input block becomes the new chain.
- R6: With `in_mode` = 2'b10 (CFB), the core always gets the chain with `core_encrypt` = 1. The output is core result XOR input. The ciphertext (the output when encrypting, the input when decrypting) becomes the new chain.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value and no new block is accepted. One cycle with `out_ready` = 1 drops `out_valid` and raises `in_ready`.
- R8: An `iv_we` pulse loads `iv_data` into the chain when no block is inside the core, and the chain then carries over from block to block. An `iv_we` pulse while a block is inside the core has no effect.
- R9: Mode, direction and data are captured at acceptance. Changing `in_mode`, `in_decrypt` or `in_data` afterwards does not affect that block.
- R10: In CBC and CFB, repeated identical input blocks give different outputs.
- R11: The reserved mode value 2'b11 behaves as ECB.
- R12: The result is taken only in the cycle `core_done` is 1, whatever the core latency. `core_din` and `core_encrypt` stay stable from `core_start` until then, and `core_dout` is ignored at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iv_we | input | 1 | Load the chaining register from `iv_data` |
| iv_data | input | 64 | Initialization vector |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Unit can take a block |
| in_data | input | 64 | Plaintext or ciphertext block |
| in_mode | input | 2 | 00 ECB, 01 CBC, 10 CFB, 11 treated as ECB |
| in_decrypt | input | 1 | 1 = decrypt, 0 = encrypt |
| core_start | output | 1 | One-cycle start pulse to the core |
| core_encrypt | output | 1 | Direction asked of the core, 1 = encrypt |
| core_din | output | 64 | Block sent to the core |
| core_done | input | 1 | Core result valid this cycle |
| core_dout | input | 64 | Core result |
| out_valid | output | 1 | Result block available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Result block |

## Verification
A wrong chaining value cannot be seen on the block that leaves it wrong. It shows up on the next CBC or CFB block, either in `out_data` or, for CBC encrypt and CFB, already in `core_din` one cycle after acceptance. The bench therefore runs chains of several blocks and decrypts them back, so a corrupted chain appears as a wrong recovered plaintext within one block. A wrong captured mode or direction shows up on `core_encrypt` as soon as `core_start` rises. The inputs are scrambled right after every acceptance so that a design that keeps reading them gives a wrong result.

// File: rtl/cipher_mode_unit.sv
module cipher_mode_unit #(
  parameter int BW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iv_we,
  input  logic [BW-1:0] iv_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [BW-1:0] in_data,
  input  logic [1:0]    in_mode,
  input  logic          in_decrypt,
  output logic          core_start,
  output logic          core_encrypt,
  output logic [BW-1:0] core_din,
  input  logic          core_done,
  input  logic [BW-1:0] core_dout,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [BW-1:0] out_data
);
  localparam logic [1:0] MODE_CBC = 2'b01;
  localparam logic [1:0] MODE_CFB = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BUSY, S_HOLD} state_t;

  state_t        st;
  logic [BW-1:0] ibuf, obuf, chain;
  logic [1:0]    mode_q;
  logic          dec_q;
  logic          is_cbc, is_cfb, accept, finish, iv_ok;
  logic [BW-1:0] result, chain_nx;

  assign is_cbc = (mode_q == MODE_CBC);
  assign is_cfb = (mode_q == MODE_CFB);
  assign accept = in_valid && (st == S_IDLE);
  assign finish = core_done && (st == S_BUSY);
  assign iv_ok  = iv_we && ((st == S_IDLE) || (st == S_HOLD));

  assign in_ready     = (st == S_IDLE);
  assign out_valid    = (st == S_HOLD);
  assign out_data     = obuf;
  assign core_start   = (st == S_START);
  assign core_encrypt = is_cfb || !dec_q;
  assign core_din     = is_cfb ? chain : ((is_cbc && !dec_q) ? (ibuf ^ chain) : ibuf);

  always_comb begin
    if (is_cfb)                result = core_dout ^ ibuf;
    else if (is_cbc && dec_q)  result = core_dout ^ chain;
    else                       result = core_dout;
    if (is_cbc)                chain_nx = dec_q ? ibuf : core_dout;
    else if (is_cfb)           chain_nx = dec_q ? ibuf : result;
    else                       chain_nx = chain;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ibuf   <= '0;
      obuf   <= '0;
      chain  <= '0;
      mode_q <= '0;
      dec_q  <= 1'b0;
    end else begin
      if (iv_ok)       chain <= iv_data;
      else if (finish) chain <= chain_nx;
      case (st)
        S_IDLE:
          if (accept) begin
            ibuf   <= in_data;
            mode_q <= in_mode;
            dec_q  <= in_decrypt;
            st     <= S_START;
          end
        S_START: st <= S_BUSY;
        S_BUSY:
          if (core_done) begin
            obuf <= result;
            st   <= S_HOLD;
          end
        S_HOLD:  if (out_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cipher_mode_unit_chk.sv
module cipher_mode_unit_chk #(
  parameter int BW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          core_start,
  input logic          core_encrypt,
  input logic [BW-1:0] core_din,
  input logic          core_done,
  input logic          out_valid,
  input logic          out_ready,
  input logic [BW-1:0] out_data
);
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (in_ready && !out_valid && !core_start));

  assert_start_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> core_start);

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);

  assert_start_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> $past(in_valid && in_ready));

  assert_ready_vs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_output_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_core_input_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start || (!in_ready && !out_valid && !core_done)) |=>
      (out_valid || ($stable(core_din) && $stable(core_encrypt))));
endmodule

bind cipher_mode_unit cipher_mode_unit_chk #(.BW(BW)) chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .core_start(core_start), .core_encrypt(core_encrypt), .core_din(core_din),
  .core_done(core_done), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data));

// File: tb/cipher_mode_unit_test.sv
module cipher_mode_unit_test;
  localparam logic [63:0] KEY  = 64'h0F1E_2D3C_4B5A_6978;
  localparam logic [63:0] JUNK = 64'hDEAD_BEEF_CAFE_F00D;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        iv_we = 1'b0, in_valid = 1'b0, in_decrypt = 1'b0, out_ready = 1'b0;
  logic [63:0] iv_data = '0, in_data = '0;
  logic [1:0]  in_mode = '0;
  logic        in_ready, core_start, core_encrypt, out_valid;
  logic [63:0] core_din, out_data;
  logic        core_done = 1'b0;
  logic [63:0] core_dout = JUNK;

  int          n_chk = 0, n_bad = 0, lat = 3, cnt = 0, cycles = 0;
  logic        seen_enc = 1'b0;
  logic [63:0] cap_din = '0, ref_chain = '0;

  always #5 clk = ~clk;

  cipher_mode_unit uut (
    .clk(clk), .rst_n(rst_n), .iv_we(iv_we), .iv_data(iv_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_mode(in_mode), .in_decrypt(in_decrypt), .core_start(core_start),
    .core_encrypt(core_encrypt), .core_din(core_din), .core_done(core_done),
    .core_dout(core_dout), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  function automatic logic [63:0] fwd(input logic [63:0] x);
    return {x[50:0], x[63:51]} ^ KEY;
  endfunction
  function automatic logic [63:0] inv(input logic [63:0] y);
    logic [63:0] z;
    z = y ^ KEY;
    return {z[12:0], z[63:13]};
  endfunction

  always @(negedge clk) begin
    core_done <= 1'b0;
    core_dout <= JUNK ^ {32'(cycles), 32'(cycles)};
    if (core_start) begin
      cnt      <= lat;
      cap_din  <= core_din;
      seen_enc <= core_encrypt;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        core_done <= 1'b1;
        core_dout <= seen_enc ? fwd(cap_din) : inv(cap_din);
      end
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
        report();
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_iv(input logic [63:0] v);
    @(negedge clk);
    iv_we = 1'b1; iv_data = v;
    @(negedge clk);
    iv_we = 1'b0;
    ref_chain = v;
  endtask

  // One block; R9 is exercised every time by scrambling the inputs after acceptance.
  task automatic run_block(input logic [1:0] m, input logic d, input logic [63:0] p,
                           input int hold, input logic mid_iv, input string req,
                           output logic [63:0] res);
    logic [63:0] exp;
    logic        exp_enc;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_decrypt = d; in_data = p;
    @(negedge clk);
    chk(core_start && !in_ready, "R2", {62'd0, core_start, in_ready}, 64'd2);
    in_valid = 1'b0; in_mode = ~m; in_decrypt = ~d; in_data = ~p;
    if (mid_iv) begin
      iv_we = 1'b1; iv_data = JUNK;
      @(negedge clk);
      iv_we = 1'b0;
    end
    @(negedge clk);
    chk(!core_start, "R2", {63'd0, core_start}, 64'd0);
    while (!out_valid) @(negedge clk);
    case (m)
      2'b01: if (!d) begin exp = fwd(p ^ ref_chain); ref_chain = exp; end
             else    begin exp = inv(p) ^ ref_chain; ref_chain = p;   end
      2'b10: begin exp = fwd(ref_chain) ^ p; ref_chain = d ? p : exp; end
      default: exp = d ? inv(p) : fwd(p);
    endcase
    exp_enc = (m == 2'b10) || !d;
    res = out_data;
    chk(res == exp, req, res, exp);
    chk(seen_enc == exp_enc, req, {63'd0, seen_enc}, {63'd0, exp_enc});
    if (hold > 0) begin
      in_valid = 1'b1; in_data = ~p;
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk(out_valid && !in_ready && out_data == exp, "R7", out_data, exp);
      end
      in_valid = 1'b0;
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R7", {62'd0, out_valid, in_ready}, 64'd1);
  endtask

  task automatic test_reset();
    logic [63:0] r;
    chk(in_ready && !out_valid && !core_start, "R1",
        {61'd0, in_ready, out_valid, core_start}, 64'd4);
    ref_chain = '0;
    run_block(2'b01, 1'b0, 64'h1111_2222_3333_4444, 0, 1'b0, "R1", r);
  endtask

  task automatic test_ecb();
    logic [63:0] c1, c2, r;
    run_block(2'b00, 1'b0, 64'h0123_4567_89AB_CDEF, 0, 1'b0, "R3", c1);
    run_block(2'b00, 1'b0, 64'h0123_4567_89AB_CDEF, 0, 1'b0, "R3", c2);
    chk(c1 == c2, "R3", c2, c1);
    run_block(2'b00, 1'b1, c1, 0, 1'b0, "R3", r);
    chk(r == 64'h0123_4567_89AB_CDEF, "R3", r, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic test_chain(input logic [1:0] m, input string req);
    logic [63:0] c0, c1, c2, r;
    logic [63:0] pt = 64'hA5A5_5A5A_0000_FFFF;
    set_iv(64'h1357_9BDF_2468_ACE0);
    run_block(m, 1'b0, pt, 0, 1'b0, req, c0);
    run_block(m, 1'b0, pt, 0, 1'b0, req, c1);
    run_block(m, 1'b0, pt, 0, 1'b0, req, c2);
    chk(c0 != c1 && c1 != c2 && c0 != c2, "R10", c1, c0);
    set_iv(64'h1357_9BDF_2468_ACE0);
    run_block(m, 1'b1, c0, 0, 1'b0, req, r);
    chk(r == pt, "R8", r, pt);
    run_block(m, 1'b1, c1, 0, 1'b0, req, r);
    chk(r == pt, "R8", r, pt);
    run_block(m, 1'b1, c2, 0, 1'b0, req, r);
    chk(r == pt, req, r, pt);
  endtask

  task automatic test_iv_busy();
    logic [63:0] r;
    set_iv(64'hFEDC_BA98_7654_3210);
    run_block(2'b01, 1'b0, 64'h0000_0000_0000_0001, 0, 1'b1, "R8", r);
    run_block(2'b10, 1'b0, 64'h0000_0000_0000_0002, 0, 1'b1, "R8", r);
  endtask

  task automatic test_hold();
    logic [63:0] r;
    set_iv(64'h0F0F_0F0F_F0F0_F0F0);
    run_block(2'b10, 1'b1, 64'h8000_0000_0000_0001, 5, 1'b0, "R7", r);
    run_block(2'b01, 1'b1, 64'h7FFF_FFFF_FFFF_FFFE, 3, 1'b0, "R7", r);
  endtask

  task automatic test_reserved();
    logic [63:0] r;
    run_block(2'b11, 1'b0, 64'h5555_AAAA_5555_AAAA, 0, 1'b0, "R11", r);
    run_block(2'b11, 1'b1, 64'h5555_AAAA_5555_AAAA, 0, 1'b0, "R11", r);
  endtask

  task automatic test_latency();
    logic [63:0] r;
    set_iv(64'h2222_4444_6666_8888);
    lat = 1;
    run_block(2'b01, 1'b0, 64'h9999_0000_9999_0000, 0, 1'b0, "R12", r);
    lat = 9;
    run_block(2'b10, 1'b1, 64'h0000_9999_0000_9999, 0, 1'b0, "R12", r);
    run_block(2'b00, 1'b1, 64'h1234_0000_0000_4321, 0, 1'b0, "R12", r);
    lat = 3;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_ecb();
    test_chain(2'b01, "R4");
    test_chain(2'b10, "R6");
    begin
      logic [63:0] r;
      set_iv(64'h0BAD_F00D_0BAD_F00D);
      run_block(2'b01, 1'b1, 64'h6666_7777_8888_9999, 0, 1'b0, "R5", r);
      run_block(2'b10, 1'b1, 64'h6666_7777_8888_9999, 0, 1'b0, "R9", r);
    end
    test_iv_busy();
    test_hold();
    test_reserved();
    test_latency();
    report();
  end
endmodule